// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single output line. A host loads a character with a one-cycle write strobe. The character waits in a holding register until the serializer is free. The serializer then sends a low start bit, the data bits starting with the least significant, an optional parity bit and a high stop period. One character can wait in the holding register while another is being shifted out. When a new character is already waiting as a stop period ends, frames follow each other with no gap.

All timing comes from the transmitter clock. A baud-factor setting chooses how many clock periods make one bit time. Character length, parity, stop length and baud factor are sampled when a character enters the serializer. The frame on the line therefore does not change if the configuration moves while the frame is being sent. A character can only begin when the enable bit is set and the active-low clear-to-send input is low. Clearing the enable cuts the current frame short. The serial output register updates only on the falling edge of the clock.

Top module: `sertx_top`

## Requirements
- R1: Reset state and idle line:
  - While reset is applied and after it is released, `txd` is 1, `ready` is 1 and `empty` is 1.
  - `txd` stays 1 whenever no frame is in progress.
- R2: Start gating:
  - A character moves into the serializer only on a rising edge where `tx_en` is 1 and `cts_n` is 0.
  - Raising `cts_n` during a frame does not stop that frame. It does prevent the next one from starting.
- R3: Frame format: one start bit at 0, then the data bits least significant first, then the stop period at 1.
- R4: Character length:
  - `len_sel` values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits.
  - Data bits above the selected length are not sent.
- R5: Parity:
  - When `par_en` is 1, one parity bit follows the most significant data bit.
  - With `par_odd` at 0 the bit makes the count of ones even. With `par_odd` at 1 it makes the count odd.
  - When `par_en` is 0, no parity bit is sent.
- R6: Stop length: `stop_sel` 0 gives 1 bit time, 1 gives 1.5 bit times, and 2 or 3 give 2 bit times.
- R7: Bit time: `baud_sel` 0 gives 1 clock period per bit, 1 gives 16, and 2 or 3 give 64.
- R8: With a baud factor of 1, a `stop_sel` of 1 gives 2 bit times of stop.
- R9: Output timing:
  - `txd` changes only on falling clock edges.
  - When the block is idle and enabled, the start bit appears on the second falling edge after the rising edge that samples `wr_stb`.
- R10: Status flags:
  - `ready` is 1 exactly when the holding register is empty.
  - `empty` is 1 exactly when both the holding register and the serializer are empty.
- R11: Holding register:
  - A character written while another is shifting is held. It starts immediately after the current stop period ends, with no idle time in between.
  - A write while `ready` is 0 is ignored.
- R12: Abort:
  - When `tx_en` is 0 on a rising edge, the frame in progress is abandoned and `txd` returns to 1 at the next falling edge.
  - A character in the holding register is kept and is sent once `tx_en` is 1 again.
- R13: Configuration sampling: the length, parity, stop and baud settings in effect when a character enters the serializer apply to the whole of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmitter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| tx_en | input | 1 | Transmit enable; 0 blocks new frames and abandons the current one |
| cts_n | input | 1 | Active-low clear-to-send; must be 0 for a frame to start |
| len_sel | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | 1 appends a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel | input | 2 | Stop period: 0 = 1 bit, 1 = 1.5 bits, 2 or 3 = 2 bits |
| baud_sel | input | 2 | Clocks per bit: 0 = 1, 1 = 16, 2 or 3 = 64 |
| txd | output | 1 | Serial data, 1 when idle |
| ready | output | 1 | Holding register empty; a new character can be written |
| empty | output | 1 | Holding register and serializer both empty |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled on the rising edge. This includes `tx_en` and `cts_n`: the start-gating property looks only at their values on the edge before a frame begins, and does not account for a glitch between edges. The bench changes every input one time unit after a rising edge and reads `txd` one time unit after a falling edge. This keeps stimulus and observation clear of both clock edges. Configuration changes happen either while the block is idle or after a frame has started, which is when the sampling rule applies.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] baud_sel;
    logic [1:0] stop_sel;
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
  } frame_cfg_t;

endpackage

// File: rtl/sertx_timing.sv
module sertx_timing #(
  parameter int MIN_LEN    = 5,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64,
  parameter int CW         = 8,
  parameter int IW         = 3
) (
  input  logic [1:0]    baud_sel,
  input  logic [1:0]    stop_sel,
  input  logic [1:0]    len_sel,
  output logic [CW-1:0] bit_clks,
  output logic [CW-1:0] stop_clks,
  output logic [IW-1:0] last_idx
);

  localparam logic [CW-1:0] ONE_CLK = CW'(1);
  localparam logic [CW-1:0] MID_CLK = CW'(FACTOR_MID);
  localparam logic [CW-1:0] HI_CLK  = CW'(FACTOR_HI);

  // Clock periods in one bit time.
  always_comb begin
    unique case (baud_sel)
      2'd0:    bit_clks = ONE_CLK;
      2'd1:    bit_clks = MID_CLK;
      default: bit_clks = HI_CLK;
    endcase
  end

  // Stop period in clock periods. A half bit cannot be formed at factor 1,
  // so 1.5 rounds up to 2 there.
  always_comb begin
    unique case (stop_sel)
      2'd0:    stop_clks = bit_clks;
      2'd1:    stop_clks = (bit_clks == ONE_CLK) ? CW'(2)
                                                 : bit_clks + (bit_clks >> 1);
      default: stop_clks = bit_clks << 1;
    endcase
  end

  assign last_idx = IW'(MIN_LEN - 1) + IW'(len_sel);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take) begin
      full_d = 1'b0;
    end
    if (wr_stb && !full_q) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take && wr_stb) |=> (full_q && $stable(data_q))); // R11

  AST_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q); // R11

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64,
  parameter int CW         = 8,
  parameter int IW         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_char,
  input  logic [DATA_W-1:0] char_data,
  input  frame_cfg_t        cfg_in,
  input  logic              start_ok,
  input  logic              abort,
  output logic              take,
  output logic              busy,
  output logic              line
);

  tx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     bidx_q, bidx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              par_q, par_d;
  frame_cfg_t        cfg_q, cfg_d;

  logic [CW-1:0]     bit_clks;
  logic [CW-1:0]     stop_clks;
  logic [IW-1:0]     last_idx;
  logic              bit_end;
  logic              stop_end;
  logic              slot_free;
  logic              load;

  // Timing is decoded from the configuration sampled at frame start.
  sertx_timing #(
    .MIN_LEN    (MIN_LEN),
    .FACTOR_MID (FACTOR_MID),
    .FACTOR_HI  (FACTOR_HI),
    .CW         (CW),
    .IW         (IW)
  ) u_timing (
    .baud_sel  (cfg_q.baud_sel),
    .stop_sel  (cfg_q.stop_sel),
    .len_sel   (cfg_q.len_sel),
    .bit_clks  (bit_clks),
    .stop_clks (stop_clks),
    .last_idx  (last_idx)
  );

  assign bit_end   = (cnt_q == bit_clks - CW'(1));
  assign stop_end  = (cnt_q == stop_clks - CW'(1));
  assign slot_free = (state_q == ST_IDLE) || ((state_q == ST_STOP) && stop_end);
  assign load      = have_char && start_ok && !abort && slot_free;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    shreg_d = shreg_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    if (abort) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (load) begin
      state_d = ST_START;
      cnt_d   = '0;
      bidx_d  = '0;
      shreg_d = char_data;
      par_d   = 1'b0;
      cfg_d   = cfg_in;
    end else begin
      unique case (state_q)
        ST_START: begin
          if (bit_end) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_d   = '0;
            par_d   = par_q ^ shreg_q[0];
            shreg_d = shreg_q >> 1;
            if (bidx_q == last_idx) begin
              state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
            end else begin
              bidx_d = bidx_q + IW'(1);
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            state_d = ST_STOP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_STOP: begin
          if (stop_end) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = par_q ^ cfg_q.par_odd;
      default:  line = 1'b1;
    endcase
  end

  assign take = load;
  assign busy = (state_q != ST_IDLE);

  AST_START_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && !abort) |=> (state_q == ST_START || state_q == ST_DATA)); // R3

  AST_NO_PAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !cfg_q.par_en) |=> (state_q != ST_PAR)); // R5

  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (cnt_q < stop_clks)); // R6

  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START || state_q == ST_DATA || state_q == ST_PAR) |-> (cnt_q < bit_clks)); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !load) |=> $stable(cfg_q)); // R13

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  input  logic [1:0]        baud_sel,
  output logic              txd,
  output logic              ready,
  output logic              empty
);

  localparam int CW = $clog2(2 * FACTOR_HI + 1);
  localparam int IW = $clog2(DATA_W);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_s_n;
  logic                  buf_full;
  logic [DATA_W-1:0]     buf_data;
  logic                  take;
  logic                  busy;
  logic                  line;
  logic                  start_ok;
  logic                  abort;
  logic                  txd_q;
  frame_cfg_t            cfg_in;

  // Reset asserts at once and releases after RST_STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe_q[RST_STAGES-1];

  assign start_ok        = tx_en && !cts_n;
  assign abort           = !tx_en;
  assign cfg_in.baud_sel = baud_sel;
  assign cfg_in.stop_sel = stop_sel;
  assign cfg_in.len_sel  = len_sel;
  assign cfg_in.par_en   = par_en;
  assign cfg_in.par_odd  = par_odd;

  sertx_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (take),
    .full    (buf_full),
    .data    (buf_data)
  );

  sertx_shift #(
    .DATA_W     (DATA_W),
    .MIN_LEN    (MIN_LEN),
    .FACTOR_MID (FACTOR_MID),
    .FACTOR_HI  (FACTOR_HI),
    .CW         (CW),
    .IW         (IW)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .have_char (buf_full),
    .char_data (buf_data),
    .cfg_in    (cfg_in),
    .start_ok  (start_ok),
    .abort     (abort),
    .take      (take),
    .busy      (busy),
    .line      (line)
  );

  // Serial output is retimed to the falling edge.
  always_ff @(negedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      txd_q <= 1'b1;
    end else begin
      txd_q <= line;
    end
  end

  assign txd   = txd_q;
  assign ready = !buf_full;
  assign empty = !buf_full && !busy;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> txd); // R1

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !$past(busy)) |-> $past(tx_en && !cts_n)); // R2

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    empty |-> ready); // R10

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !tx_en |=> !busy); // R12

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       tx_en;
  logic       cts_n;
  logic [1:0] len_sel;
  logic       par_en;
  logic       par_odd;
  logic [1:0] stop_sel;
  logic [1:0] baud_sel;
  logic       txd;
  logic       ready;
  logic       empty;

  int n_vec = 0;
  int n_bad = 0;
  bit pending_start = 1'b0;

  sertx_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .tx_en    (tx_en),
    .cts_n    (cts_n),
    .len_sel  (len_sel),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .stop_sel (stop_sel),
    .baud_sel (baud_sel),
    .txd      (txd),
    .ready    (ready),
    .empty    (empty)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  function automatic int fac(input int b);
    return (b == 0) ? 1 : (b == 1) ? 16 : 64;
  endfunction

  function automatic int exp_stop(input int b, input int s);
    int f;
    f = fac(b);
    if (s == 0) return f;
    if (s == 1) return (f == 1) ? 2 : f + f / 2;
    return 2 * f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int l, input int pe, input int po,
                         input int s, input int b);
    len_sel  = 2'(l);
    par_en   = 1'(pe);
    par_odd  = 1'(po);
    stop_sel = 2'(s);
    baud_sel = 2'(b);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(posedge clk); #1;
    wr_stb  = 1'b1;
    wr_data = d;
    @(posedge clk); #1;
    wr_stb  = 1'b0;
  endtask

  task automatic wait_ready();
    int g;
    g = 0;
    while (!ready && g < 5000) begin
      @(posedge clk); #1;
      g++;
    end
  endtask

  // Line receiver: samples mid-bit, then measures the high run after the frame.
  task automatic rx_frame(input int f, input int nb, input int pen,
                          output logic st, output logic [7:0] d,
                          output logic p, output int gap);
    int idx;
    int guard;
    int nbit;
    int cap;
    st = 1'b1; d = '0; p = 1'b0; gap = 0; guard = 0;
    cap = 3 * f + 8;
    if (!pending_start) begin
      do begin
        @(negedge clk); #1;
        guard++;
      end while (txd !== 1'b0 && guard < 20000);
    end
    pending_start = 1'b0;
    idx  = 0;
    nbit = 1 + nb + pen;
    for (int k = 0; k < nbit; k++) begin
      while (idx < k * f + f / 2) begin
        @(negedge clk); #1;
        idx++;
      end
      if (k == 0) st = txd;
      else if (k <= nb) d[k-1] = txd;
      else p = txd;
    end
    while (idx < nbit * f) begin
      @(negedge clk); #1;
      idx++;
    end
    while (gap < cap) begin
      if (txd === 1'b0) begin
        pending_start = 1'b1;
        break;
      end
      gap++;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(ready === 1'b1 && empty === 1'b1, "R1", "ready&empty in reset",
        int'({ready, empty}), 3);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(txd === 1'b1 && ready === 1'b1 && empty === 1'b1, "R1",
        "txd/ready/empty after reset", int'({txd, ready, empty}), 7);
  endtask

  task automatic t_basic();
    logic st, p; logic [7:0] d; int gap;
    set_cfg(3, 0, 0, 0, 1);
    do_write(8'hA5);
    chk(ready == 1'b0 && empty == 1'b0, "R10", "flags after write",
        int'({ready, empty}), 0);
    @(negedge clk); #1;
    chk(txd == 1'b1, "R9", "txd at first falling edge", int'(txd), 1);
    @(posedge clk); #1;
    chk(txd == 1'b1, "R9", "txd unchanged at rising edge", int'(txd), 1);
    chk(ready == 1'b1 && empty == 1'b0, "R10", "flags after transfer",
        int'({ready, empty}), 2);
    @(negedge clk); #1;
    chk(txd == 1'b0, "R9", "start bit at second falling edge", int'(txd), 0);
    pending_start = 1'b1;
    rx_frame(16, 8, 0, st, d, p, gap);
    chk(st == 1'b0, "R3", "start bit level", int'(st), 0);
    chk(d == 8'hA5, "R3", "data LSB first", int'(d), 'hA5);
    chk(gap >= 16 && !pending_start, "R3", "stop then idle high", gap, 56);
    chk(empty == 1'b1 && ready == 1'b1, "R10", "flags when drained",
        int'({ready, empty}), 3);
  endtask

  task automatic t_lengths();
    logic st, p; logic [7:0] d; int gap;
    logic [7:0] v, m;
    for (int l = 0; l < 4; l++) begin
      set_cfg(l, 0, 0, 0, 0);
      m = 8'((1 << (5 + l)) - 1);
      v = (l == 3) ? 8'h5A : (8'hFF & ~(8'd1 << (5 + l)));
      do_write(v);
      rx_frame(1, 5 + l, 0, st, d, p, gap);
      chk(d == (v & m), "R4", "short character data", int'(d), int'(v & m));
      chk(gap == 11 && !pending_start, "R4", "no bit past length", gap, 11);
    end
  endtask

  task automatic t_parity();
    logic st, p; logic [7:0] d; int gap;
    logic [7:0] vals [4];
    int odds [4];
    logic ep;
    vals[0] = 8'h35; odds[0] = 0;
    vals[1] = 8'h35; odds[1] = 1;
    vals[2] = 8'h6E; odds[2] = 0;
    vals[3] = 8'h00; odds[3] = 1;
    for (int i = 0; i < 4; i++) begin
      set_cfg(2, 1, odds[i], 0, 1);
      do_write(vals[i]);
      rx_frame(16, 7, 1, st, d, p, gap);
      ep = (^(vals[i] & 8'h7F)) ^ 1'(odds[i]);
      chk(d == (vals[i] & 8'h7F), "R5", "data before parity", int'(d),
          int'(vals[i] & 8'h7F));
      chk(p == ep, "R5", "parity bit", int'(p), int'(ep));
    end
  endtask

  task automatic t_stop_baud();
    logic st, p; logic [7:0] d; int gap;
    for (int b = 0; b < 3; b++) begin
      for (int s = 0; s < 4; s++) begin
        set_cfg(3, 0, 0, s, b);
        fork
          rx_frame(fac(b), 8, 0, st, d, p, gap);
          begin
            do_write(8'h3C);
            wait_ready();
            do_write(8'hC3);
          end
        join
        chk(d == 8'h3C, "R7", "data at chosen bit time", int'(d), 'h3C);
        if (b == 0 && s == 1)
          chk(gap == exp_stop(b, s), "R8", "1.5 stop at factor 1", gap, exp_stop(b, s));
        else
          chk(gap == exp_stop(b, s), "R6", "stop length", gap, exp_stop(b, s));
        chk(pending_start == 1'b1, "R11", "second frame follows at once",
            int'(pending_start), 1);
        rx_frame(fac(b), 8, 0, st, d, p, gap);
        chk(d == 8'hC3, "R11", "buffered character", int'(d), 'hC3);
      end
    end
  endtask

  task automatic t_overwrite();
    logic st, p; logic [7:0] d; int gap;
    set_cfg(3, 0, 0, 0, 1);
    fork
      rx_frame(16, 8, 0, st, d, p, gap);
      begin
        do_write(8'h11);
        wait_ready();
        do_write(8'h22);
        do_write(8'h33);
      end
    join
    chk(d == 8'h11, "R11", "first character", int'(d), 'h11);
    rx_frame(16, 8, 0, st, d, p, gap);
    chk(d == 8'h22, "R11", "held character kept", int'(d), 'h22);
    chk(!pending_start && gap == 56, "R11", "write while full ignored", gap, 56);
  endtask

  task automatic t_cts();
    logic st, p; logic [7:0] d; int gap;
    int lows;
    set_cfg(3, 0, 0, 0, 1);
    cts_n = 1'b1;
    do_write(8'h81);
    lows = 0;
    repeat (40) begin
      @(negedge clk); #1;
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, "R2", "no start with cts_n high", lows, 0);
    chk(ready == 1'b0 && empty == 1'b0, "R2", "character held", int'({ready, empty}), 0);
    tx_en = 1'b0;
    cts_n = 1'b0;
    lows  = 0;
    repeat (40) begin
      @(negedge clk); #1;
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, "R2", "no start with enable low", lows, 0);
    tx_en = 1'b1;
    rx_frame(16, 8, 0, st, d, p, gap);
    chk(d == 8'h81, "R2", "sent once allowed", int'(d), 'h81);
    fork
      rx_frame(16, 8, 0, st, d, p, gap);
      begin
        do_write(8'h42);
        repeat (20) @(posedge clk);
        #1;
        cts_n = 1'b1;
        do_write(8'h99);
      end
    join
    chk(d == 8'h42 && st == 1'b0, "R2", "frame completes after cts_n rises", int'(d), 'h42);
    chk(!pending_start, "R2", "next frame blocked", int'(pending_start), 0);
    chk(ready == 1'b0, "R2", "blocked character held", int'(ready), 0);
    cts_n = 1'b0;
    rx_frame(16, 8, 0, st, d, p, gap);
    chk(d == 8'h99, "R2", "blocked character sent", int'(d), 'h99);
  endtask

  task automatic t_abort();
    logic st, p; logic [7:0] d; int gap;
    int lows;
    set_cfg(3, 0, 0, 0, 1);
    do_write(8'hF0);
    repeat (30) @(posedge clk);
    do_write(8'h0F);
    @(negedge clk); #1;
    chk(txd == 1'b0, "R12", "line low before abort", int'(txd), 0);
    @(posedge clk); #1;
    tx_en = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    chk(txd == 1'b1, "R12", "line high after abort", int'(txd), 1);
    lows = 0;
    repeat (60) begin
      @(negedge clk); #1;
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, "R12", "stays high while disabled", lows, 0);
    chk(ready == 1'b0 && empty == 1'b0, "R12", "held character kept",
        int'({ready, empty}), 0);
    tx_en = 1'b1;
    rx_frame(16, 8, 0, st, d, p, gap);
    chk(d == 8'h0F, "R12", "held character sent on re-enable", int'(d), 'h0F);
  endtask

  task automatic t_snapshot();
    logic st, p; logic [7:0] d; int gap;
    set_cfg(3, 0, 0, 0, 1);
    fork
      rx_frame(16, 8, 0, st, d, p, gap);
      begin
        do_write(8'h6B);
        repeat (5) @(posedge clk);
        #1;
        set_cfg(0, 1, 1, 1, 0);
      end
    join
    chk(d == 8'h6B, "R13", "frame keeps start config", int'(d), 'h6B);
    chk(gap == 56 && !pending_start, "R13", "stop and idle unaffected", gap, 56);
    set_cfg(3, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = '0;
    tx_en   = 1'b1;
    cts_n   = 1'b0;
    set_cfg(3, 0, 0, 0, 1);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stop_baud();
    t_overwrite();
    t_cts();
    t_abort();
    t_snapshot();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule